// File: doc/BRIEF.md
# Proactive Garbage-Collection Gate

This block decides when a flash storage module may spend time on garbage collection without host requests seeing the stall. Collection runs in two phases. First, valid pages are copied one page per step. Then the source block is erased. The gate takes the counts of requests that do not depend on the blocked resource: entries waiting in the buffer, queued flash reads and queued flash writes. It multiplies each count by its per-request time in nanoseconds. The sum is the latency budget that the other work can hide.

A copy step is permitted when that budget is strictly greater than the access latency of the blocked channel, or when no queued request targets the blocked channel. An erase is permitted at once if the budget covers the erase time. Otherwise the gate works out how many reads from the unit about to be erased must be prefetched into the buffer. It divides the shortfall by the bus transfer time, rounding up, using one subtraction per cycle. It then withholds the erase grant until the flash controller has reported that many completed prefetches.

The controller holds `erase_req` high for the whole erase sequence and keeps the timing and count inputs stable while a sequence is being computed.

Top module: `gc_gate`

## Requirements
- R1: After reset, `copy_grant`, `erase_grant` and `pf_active` are 0 and `pf_need` is 0.
- R2: The latency budget is `n_buf*t_bus + n_rd*t_rd + n_wr*t_wr`, held in a register. If the sum exceeds 2^32-1 it saturates to 32'hFFFF_FFFF instead of wrapping.
- R3: With `copy_req` high and `blk_req` high, `copy_grant` is 1 only when the budget is strictly greater than `t_blk`. Equality denies the step.
- R4: With `copy_req` high and `blk_req` low, `copy_grant` is 1 whatever the budget. With `copy_req` low, `copy_grant` is 0.
- R5: While an erase sequence is in progress (from the cycle after `erase_req` is accepted until it returns to idle), `copy_grant` is held at 0.
- R6: If the budget is greater than or equal to `t_erase`, `erase_grant` rises without any prefetch phase (`pf_active` stays 0) and `pf_need` is 0.
- R7: Otherwise `pf_need` becomes ceil((`t_erase` - budget) / `t_bus`). `pf_active` is then 1, and `pf_need` stays constant while `pf_active` is 1.
- R8: While `pf_active` is 1, each cycle with `pf_done` high counts one finished prefetch. `erase_grant` rises once the count reaches `pf_need`. A `pf_done` pulse given outside this phase has no effect on the count.
- R9: If `t_bus` is 0 when a prefetch is needed, `pf_need` is 32'hFFFF_FFFF.
- R10: Dropping `erase_req` in any state returns the gate to idle on the next clock. This clears `erase_grant` and `pf_active` and sets `pf_need` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_buf | input | 8 | Buffered requests not blocked by collection |
| n_rd | input | 8 | Pending flash reads not blocked by collection |
| n_wr | input | 8 | Pending flash writes not blocked by collection |
| t_bus | input | 32 | Bus transfer time per request, ns |
| t_rd | input | 32 | Flash page read time, ns |
| t_wr | input | 32 | Flash page write time, ns |
| t_blk | input | 32 | Access latency of the blocked channel, ns |
| t_erase | input | 32 | Block erase time, ns |
| blk_req | input | 1 | Some queued request targets the blocked channel |
| copy_req | input | 1 | A page-copy step is requested |
| erase_req | input | 1 | Block erase requested, held for the whole sequence |
| pf_done | input | 1 | One prefetch from the erased unit completed |
| copy_grant | output | 1 | Current copy step may proceed |
| erase_grant | output | 1 | Erase may start |
| pf_active | output | 1 | Prefetch phase in progress |
| pf_need | output | 32 | Number of prefetches required before the erase |

## Verification
A copy step and an erase can both be requested in the same cycle, and the gate must then favour the erase sequence. The bench sets up a load that on its own would win `copy_grant`, holds `copy_req` high, and raises `erase_req` with a budget short enough to force a prefetch phase. The copy permission must fall to 0 and stay there through `pf_active`. The erase must still reach its grant after the expected number of `pf_done` pulses.

// File: rtl/gcg_pkg.sv
package gcg_pkg;

  typedef enum logic [2:0] {
    ES_IDLE  = 3'd0,
    ES_CALC  = 3'd1,
    ES_DIV   = 3'd2,
    ES_WAIT  = 3'd3,
    ES_GRANT = 3'd4
  } erase_st_e;

  localparam int unsigned N_TERMS = 3;

endpackage

// File: rtl/gcg_resp_calc.sv
module gcg_resp_calc #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned T_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] n_buf,
  input  logic [CNT_W-1:0] n_rd,
  input  logic [CNT_W-1:0] n_wr,
  input  logic [T_W-1:0]   t_bus,
  input  logic [T_W-1:0]   t_rd,
  input  logic [T_W-1:0]   t_wr,
  output logic [T_W-1:0]   resp_q
);
  import gcg_pkg::*;

  localparam int unsigned PROD_W = CNT_W + T_W;
  localparam int unsigned SUM_W  = PROD_W + 2;

  logic [CNT_W-1:0]  cnt_a  [N_TERMS];
  logic [T_W-1:0]    lat_a  [N_TERMS];
  logic [PROD_W-1:0] prod_a [N_TERMS];
  logic [SUM_W-1:0]  sum_c;
  logic [T_W-1:0]    resp_d;

  assign cnt_a[0] = n_buf;
  assign cnt_a[1] = n_rd;
  assign cnt_a[2] = n_wr;
  assign lat_a[0] = t_bus;
  assign lat_a[1] = t_rd;
  assign lat_a[2] = t_wr;

  // One widened product per load term
  for (genvar gi = 0; gi < N_TERMS; gi++) begin : g_term
    assign prod_a[gi] = {{T_W{1'b0}}, cnt_a[gi]} * {{CNT_W{1'b0}}, lat_a[gi]};
  end

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < N_TERMS; i++) begin
      sum_c = sum_c + {2'b00, prod_a[i]};
    end
    if (|sum_c[SUM_W-1:T_W]) begin
      resp_d = '1;
    end else begin
      resp_d = sum_c[T_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= '0;
    end else begin
      resp_q <= resp_d;
    end
  end

endmodule

// File: rtl/gcg_copy_gate.sv
module gcg_copy_gate #(
  parameter int unsigned T_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           copy_req,
  input  logic           blk_req,
  input  logic           erase_busy,
  input  logic [T_W-1:0] resp,
  input  logic [T_W-1:0] t_blk,
  output logic           copy_grant
);

  logic hides_c;
  logic grant_d;
  logic grant_q;

  always_comb begin
    hides_c = (resp > t_blk);
    grant_d = copy_req && !erase_busy && (!blk_req || hides_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
    end else begin
      grant_q <= grant_d;
    end
  end

  assign copy_grant = grant_q;

endmodule

// File: rtl/gcg_erase_seq.sv
module gcg_erase_seq #(
  parameter int unsigned T_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           erase_req,
  input  logic           pf_done,
  input  logic [T_W-1:0] resp,
  input  logic [T_W-1:0] t_bus,
  input  logic [T_W-1:0] t_erase,
  output logic           erase_busy,
  output logic           erase_grant,
  output logic           pf_active,
  output logic [T_W-1:0] pf_need,
  output logic [T_W-1:0] done_cnt
);
  import gcg_pkg::*;

  erase_st_e    st_q, st_d;
  logic [T_W-1:0] rem_q, rem_d;
  logic [T_W-1:0] quo_q, quo_d;
  logic [T_W-1:0] done_q, done_d;
  logic [T_W:0]   done_sum;

  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    quo_d    = quo_q;
    done_d   = done_q;
    done_sum = {1'b0, done_q} + {{T_W{1'b0}}, pf_done};
    case (st_q)
      ES_IDLE: begin
        if (erase_req) st_d = ES_CALC;
      end
      ES_CALC: begin
        done_d = '0;
        if (resp >= t_erase) begin
          quo_d = '0;
          st_d  = ES_GRANT;
        end else if (t_bus == '0) begin
          quo_d = '1;
          st_d  = ES_WAIT;
        end else begin
          rem_d = t_erase - resp;
          quo_d = '0;
          st_d  = ES_DIV;
        end
      end
      ES_DIV: begin
        // one subtraction per cycle, last partial step rounds up
        quo_d = quo_q + 1'b1;
        if (rem_q > t_bus) begin
          rem_d = rem_q - t_bus;
        end else begin
          rem_d = '0;
          st_d  = ES_WAIT;
        end
      end
      ES_WAIT: begin
        if (pf_done) done_d = done_sum[T_W-1:0];
        if (done_sum >= {1'b0, quo_q}) st_d = ES_GRANT;
      end
      ES_GRANT: begin
        st_d = ES_GRANT;
      end
      default: begin
        st_d = ES_IDLE;
      end
    endcase
    if (!erase_req && (st_q != ES_IDLE)) begin
      st_d   = ES_IDLE;
      quo_d  = '0;
      rem_d  = '0;
      done_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ES_IDLE;
      rem_q  <= '0;
      quo_q  <= '0;
      done_q <= '0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      done_q <= done_d;
    end
  end

  assign erase_busy  = (st_q != ES_IDLE);
  assign erase_grant = (st_q == ES_GRANT);
  assign pf_active   = (st_q == ES_WAIT);
  assign pf_need     = quo_q;
  assign done_cnt    = done_q;

endmodule

// File: rtl/gc_gate.sv
module gc_gate #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned T_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] n_buf,
  input  logic [CNT_W-1:0] n_rd,
  input  logic [CNT_W-1:0] n_wr,
  input  logic [T_W-1:0]   t_bus,
  input  logic [T_W-1:0]   t_rd,
  input  logic [T_W-1:0]   t_wr,
  input  logic [T_W-1:0]   t_blk,
  input  logic [T_W-1:0]   t_erase,
  input  logic             blk_req,
  input  logic             copy_req,
  input  logic             erase_req,
  input  logic             pf_done,
  output logic             copy_grant,
  output logic             erase_grant,
  output logic             pf_active,
  output logic [T_W-1:0]   pf_need
);

  logic [T_W-1:0] resp_q;
  logic           erase_busy;
  logic [T_W-1:0] done_cnt;

  gcg_resp_calc #(.CNT_W(CNT_W), .T_W(T_W)) i_resp (
    .clk    (clk),
    .rst_n  (rst_n),
    .n_buf  (n_buf),
    .n_rd   (n_rd),
    .n_wr   (n_wr),
    .t_bus  (t_bus),
    .t_rd   (t_rd),
    .t_wr   (t_wr),
    .resp_q (resp_q)
  );

  gcg_copy_gate #(.T_W(T_W)) i_copy (
    .clk        (clk),
    .rst_n      (rst_n),
    .copy_req   (copy_req),
    .blk_req    (blk_req),
    .erase_busy (erase_busy),
    .resp       (resp_q),
    .t_blk      (t_blk),
    .copy_grant (copy_grant)
  );

  gcg_erase_seq #(.T_W(T_W)) i_erase (
    .clk         (clk),
    .rst_n       (rst_n),
    .erase_req   (erase_req),
    .pf_done     (pf_done),
    .resp        (resp_q),
    .t_bus       (t_bus),
    .t_erase     (t_erase),
    .erase_busy  (erase_busy),
    .erase_grant (erase_grant),
    .pf_active   (pf_active),
    .pf_need     (pf_need),
    .done_cnt    (done_cnt)
  );

endmodule

// File: rtl/gc_gate_chk.sv
module gc_gate_chk #(
  parameter int unsigned T_W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           copy_req,
  input logic           erase_req,
  input logic           copy_grant,
  input logic           erase_grant,
  input logic           pf_active,
  input logic [T_W-1:0] pf_need,
  input logic [T_W-1:0] done_cnt
);

  // R4: a copy permission always follows a copy request
  p_copy_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_grant |-> $past(copy_req));

  // R5: no copy permission during prefetch or erase grant
  p_copy_vs_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    copy_grant |-> (!pf_active && !erase_grant));

  // R7: prefetch target constant through the prefetch phase
  p_need_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_active && $past(pf_active)) |-> $stable(pf_need));

  // R8: erase granted only once enough prefetches are counted
  p_grant_after_pf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_grant) |-> (done_cnt >= pf_need));

  // R10: grant never outlives the request by more than one cycle
  p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_grant |-> $past(erase_req));

endmodule

bind gc_gate gc_gate_chk #(.T_W(T_W)) i_gc_gate_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .copy_req    (copy_req),
  .erase_req   (erase_req),
  .copy_grant  (copy_grant),
  .erase_grant (erase_grant),
  .pf_active   (pf_active),
  .pf_need     (pf_need),
  .done_cnt    (done_cnt)
);

// File: tb/test_gc_gate.sv
module test_gc_gate;

  logic        clk;
  logic        rst_n;
  logic [7:0]  n_buf, n_rd, n_wr;
  logic [31:0] t_bus, t_rd, t_wr, t_blk, t_erase;
  logic        blk_req, copy_req, erase_req, pf_done;
  logic        copy_grant, erase_grant, pf_active;
  logic [31:0] pf_need;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_f = 1'b0;

  gc_gate i_gc_gate (
    .clk(clk), .rst_n(rst_n),
    .n_buf(n_buf), .n_rd(n_rd), .n_wr(n_wr),
    .t_bus(t_bus), .t_rd(t_rd), .t_wr(t_wr),
    .t_blk(t_blk), .t_erase(t_erase),
    .blk_req(blk_req), .copy_req(copy_req),
    .erase_req(erase_req), .pf_done(pf_done),
    .copy_grant(copy_grant), .erase_grant(erase_grant),
    .pf_active(pf_active), .pf_need(pf_need)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] budget(input int unsigned nb, nr, nw,
                                         input logic [31:0] tb, tr, tw);
    longint unsigned s;
    s = longint'(nb) * tb + longint'(nr) * tr + longint'(nw) * tw;
    return (s > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : s[31:0];
  endfunction

  function automatic logic [31:0] need_of(input logic [31:0] b, te, tb);
    longint unsigned r;
    r = longint'(te) - longint'(b);
    return 32'((r + tb - 1) / tb);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input int unsigned nb, nr, nw);
    n_buf = 8'(nb); n_rd = 8'(nr); n_wr = 8'(nw);
  endtask

  task automatic pulse_done();
    pf_done = 1'b1;
    cyc(1);
    pf_done = 1'b0;
  endtask

  // raise erase and wait for the sequence to settle
  task automatic start_erase();
    erase_req = 1'b1;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (pf_active || erase_grant) break;
    end
  endtask

  task automatic end_erase();
    erase_req = 1'b0;
    cyc(1);
    chk("R10 grant cleared", 32'(erase_grant), 32'd0);
    chk("R10 pf_active cleared", 32'(pf_active), 32'd0);
    chk("R10 need cleared", pf_need, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 copy_grant", 32'(copy_grant), 32'd0);
    chk("R1 erase_grant", 32'(erase_grant), 32'd0);
    chk("R1 pf_active", 32'(pf_active), 32'd0);
    chk("R1 pf_need", pf_need, 32'd0);
  endtask

  task automatic t_copy();
    logic [31:0] b;
    t_bus = 32'd100; t_rd = 32'd50000; t_wr = 32'd650000;
    load(4, 2, 0);
    b = budget(4, 2, 0, t_bus, t_rd, t_wr);
    t_blk = b - 1; blk_req = 1'b1; copy_req = 1'b1;
    cyc(3);
    chk("R3 budget above latency", 32'(copy_grant), 32'd1);
    t_blk = b;
    cyc(3);
    chk("R3 equal budget denied", 32'(copy_grant), 32'd0);
    load(4, 0, 0);
    t_blk = 32'd50000;
    cyc(3);
    chk("R3 small budget denied", 32'(copy_grant), 32'd0);
    blk_req = 1'b0;
    cyc(3);
    chk("R4 no blocked request", 32'(copy_grant), 32'd1);
    copy_req = 1'b0;
    cyc(3);
    chk("R4 no copy request", 32'(copy_grant), 32'd0);
  endtask

  task automatic t_erase_now();
    t_bus = 32'd20000; t_rd = 32'd50000; t_wr = 32'd650000;
    t_erase = 32'd2000000;
    load(0, 0, 4);
    cyc(2);
    start_erase();
    chk("R6 immediate grant", 32'(erase_grant), 32'd1);
    chk("R6 no prefetch", 32'(pf_active), 32'd0);
    chk("R6 need zero", pf_need, 32'd0);
    end_erase();
    load(0, 40, 0);
    cyc(2);
    start_erase();
    chk("R6 equal budget grants", 32'(erase_grant), 32'd1);
    end_erase();
  endtask

  task automatic t_prefetch();
    logic [31:0] b;
    t_bus = 32'd20000; t_erase = 32'd2000000;
    load(0, 39, 0);
    b = budget(0, 39, 0, t_bus, t_rd, t_wr);
    blk_req = 1'b0; copy_req = 1'b1;
    cyc(3);
    chk("R4 copy granted before erase", 32'(copy_grant), 32'd1);
    start_erase();
    chk("R7 prefetch phase", 32'(pf_active), 32'd1);
    chk("R7 rounded-up need", pf_need, need_of(b, t_erase, t_bus));
    chk("R5 copy held off", 32'(copy_grant), 32'd0);
    pulse_done();
    pulse_done();
    cyc(2);
    chk("R8 grant withheld", 32'(erase_grant), 32'd0);
    pulse_done();
    cyc(1);
    chk("R8 grant after count", 32'(erase_grant), 32'd1);
    chk("R5 copy held during grant", 32'(copy_grant), 32'd0);
    copy_req = 1'b0;
    end_erase();
  endtask

  task automatic t_exact_div();
    logic [31:0] b;
    t_bus = 32'd25000;
    load(0, 38, 0);
    b = budget(0, 38, 0, t_bus, t_rd, t_wr);
    cyc(2);
    start_erase();
    chk("R7 exact division", pf_need, need_of(b, t_erase, t_bus));
    chk("R7 exact division is 4", pf_need, 32'd4);
    end_erase();
  endtask

  task automatic t_stray_done();
    t_bus = 32'd60000;
    load(0, 39, 0);
    cyc(2);
    pulse_done();
    pulse_done();
    start_erase();
    chk("R7 single prefetch", pf_need, 32'd1);
    cyc(3);
    chk("R8 earlier pulses ignored", 32'(erase_grant), 32'd0);
    pulse_done();
    cyc(1);
    chk("R8 grant after own pulse", 32'(erase_grant), 32'd1);
    end_erase();
  endtask

  task automatic t_zero_bus();
    t_bus = 32'd0;
    load(0, 10, 0);
    cyc(2);
    start_erase();
    chk("R9 zero bus time", pf_need, 32'hFFFF_FFFF);
    chk("R9 prefetch active", 32'(pf_active), 32'd1);
    end_erase();
  endtask

  task automatic t_saturate();
    t_bus = 32'hFFFF_FFFF;
    load(255, 0, 0);
    t_erase = 32'hFFFF_FFFF;
    t_blk = 32'hFFFF_FFFE; blk_req = 1'b1; copy_req = 1'b1;
    cyc(3);
    chk("R2 saturated budget copies", 32'(copy_grant), 32'd1);
    copy_req = 1'b0;
    cyc(2);
    start_erase();
    chk("R2 saturated budget erases", 32'(erase_grant), 32'd1);
    chk("R2 saturated need zero", pf_need, 32'd0);
    end_erase();
  endtask

  initial begin
    rst_n = 1'b0;
    n_buf = '0; n_rd = '0; n_wr = '0;
    t_bus = '0; t_rd = '0; t_wr = '0; t_blk = '0; t_erase = '0;
    blk_req = 1'b0; copy_req = 1'b0; erase_req = 1'b0; pf_done = 1'b0;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_copy();
    t_erase_now();
    t_prefetch();
    t_exact_div();
    t_stray_done();
    t_zero_bus();
    t_saturate();
    done_f = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done_f) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule